// File: doc/BRIEF.md
# Operating Mode and Stop-Recovery Controller

This block keeps the processor's operating mode configuration and manages the return from the low-power stop state. While reset is held, it samples three mode strap pins into the mode field. A sampled value of zero is promoted to mode 1, so reset can never start the part in mode 0. After reset, software can rewrite the whole configuration through a simple write port and read it back on a parallel read bus. From the current mode the block derives the program address at which execution starts. It also drives a remap enable that tells the memory decoder to move two 768-word data RAM windows into program space. One window is the X RAM at $0F00–$11FF and the other is the Y RAM at $0E00–$10FF. Together they cover program addresses $0200–$07FF.

When the core asks to stop, the block waits for a wakeup event. It then counts a restart delay and raises a single-cycle resume strobe when the count expires. A delay-select bit in the configuration chooses between a long delay of 65,535 cycles and a short delay of 8 cycles. That bit is captured at the moment the wakeup event is accepted.

Top module: `opmode_ctrl`

## Requirements
- R1: While `rst_n` is low the mode field (read bits 2:0) follows `mode_pins` and holds the last value sampled during reset; after reset `mode_pins` has no effect on any output.
- R2: A value of 0 on `mode_pins` during reset makes the mode field read 1.
- R3: A write (`cfg_we` high at a clock edge) loads mode from `cfg_wdata[2:0]` (mode 0 allowed), remap enable from bit 3, a second RAM-enable flag from bit 4 and delay-select from bit 6; `cfg_rdata` returns these at the same positions from the next cycle and reads 0 in bits 5 and 7.
- R4: Reset clears the remap enable, the second RAM-enable flag and delay-select (read bits 3, 4, 6 are 0 after reset).
- R5: `boot_addr` is 16'h2000 in mode 2, 16'h0000 in mode 0 and 16'h0800 in every other mode.
- R6: `prog_remap` equals the remap-enable bit (read bit 3) at all times.
- R7: With delay-select 1 at wakeup, `resume` goes high in the cycle that follows the 8th clock edge after the edge that accepts `wake_evt`.
- R8: With delay-select 0 at wakeup, that count is 65,535 edges.
- R9: Writing delay-select while a delay is counting does not change the length of that delay.
- R10: `resume` is high for exactly one cycle per accepted wakeup.
- R11: `wake_evt` is ignored unless the block is stopped: a wakeup while running or while counting produces no resume strobe and does not restart the count.
- R12: A `stop_req` raised during a delay count is held and takes effect once the resume strobe has fired, so the block is then stopped and waiting for a new wakeup.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| mode_pins | input | 3 | Mode strap pins, sampled only during reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_wdata | input | 8 | Configuration write data |
| cfg_rdata | output | 8 | Configuration read data |
| stop_req | input | 1 | Request to enter the stop state |
| wake_evt | input | 1 | Wakeup event, accepted only while stopped |
| resume | output | 1 | One-cycle strobe ending the restart delay |
| boot_addr | output | 16 | Program entry address for the current mode |
| prog_remap | output | 1 | Data RAM into program space remap enable |

## Verification
The hardest situation to reach is a stop request that lands in the middle of a running delay count. The request has to be held through the resume strobe and must then leave the block stopped. The stimulus stops the block and wakes it with the short delay selected. Three edges into the count it pulses `stop_req`, and at the same point in other runs it rewrites delay-select or sends a second wakeup. It then proves that the block is stopped by sending one more wakeup and timing the second strobe. The single long run changes delay-select mid-count, so it exercises both R8 and R9.

// File: rtl/opmode_pkg.sv
package opmode_pkg;

  typedef enum logic [1:0] {
    ST_RUN   = 2'd0,
    ST_STOP  = 2'd1,
    ST_DELAY = 2'd2
  } wake_st_e;

  localparam int CFG_W    = 8;
  localparam int MODE_W   = 3;
  localparam int BIT_REMAP = 3;
  localparam int BIT_RAMA  = 4;
  localparam int BIT_DSEL  = 6;

  typedef struct packed {
    logic              dsel;
    logic              rama;
    logic              remap;
    logic [MODE_W-1:0] mode;
  } cfg_t;

endpackage

// File: rtl/opmode_rst_sync.sv
module opmode_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= '0;
    end else begin
      chain_q <= {chain_q[STAGES-2:0], 1'b1};
    end
  end

  assign rst_sync_n = chain_q[STAGES-1];

endmodule

// File: rtl/opmode_cfg_reg.sv
module opmode_cfg_reg
  import opmode_pkg::*;
#(
  parameter int          ADDR_W        = 16,
  parameter logic [ADDR_W-1:0] PROM_BASE     = 16'h2000,
  parameter logic [ADDR_W-1:0] RESET_VECTOR  = 16'h0000,
  parameter logic [ADDR_W-1:0] BOOT_ROM_BASE = 16'h0800
) (
  input  logic              clk,
  input  logic              rst_sync_n,
  input  logic [MODE_W-1:0] mode_pins,
  input  logic              cfg_we,
  input  logic [CFG_W-1:0]  cfg_wdata,
  output cfg_t              cfg,
  output logic [CFG_W-1:0]  cfg_rdata,
  output logic [ADDR_W-1:0] boot_addr
);

  logic [MODE_W-1:0] mode_q, mode_d;
  logic              remap_q, remap_d;
  logic              rama_q, rama_d;
  logic              dsel_q, dsel_d;

  // Mode field: loaded synchronously from the straps for as long as reset
  // is active, so it carries no asynchronous reset of its own.
  always_comb begin
    mode_d = mode_q;
    if (!rst_sync_n) begin
      mode_d = (mode_pins == '0) ? MODE_W'(1) : mode_pins;
    end else if (cfg_we) begin
      mode_d = cfg_wdata[MODE_W-1:0];
    end
  end

  always_ff @(posedge clk) begin
    mode_q <= mode_d;
  end

  always_comb begin
    remap_d = remap_q;
    rama_d  = rama_q;
    dsel_d  = dsel_q;
    if (cfg_we) begin
      remap_d = cfg_wdata[BIT_REMAP];
      rama_d  = cfg_wdata[BIT_RAMA];
      dsel_d  = cfg_wdata[BIT_DSEL];
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      remap_q <= 1'b0;
      rama_q  <= 1'b0;
      dsel_q  <= 1'b0;
    end else begin
      remap_q <= remap_d;
      rama_q  <= rama_d;
      dsel_q  <= dsel_d;
    end
  end

  assign cfg.mode  = mode_q;
  assign cfg.remap = remap_q;
  assign cfg.rama  = rama_q;
  assign cfg.dsel  = dsel_q;

  always_comb begin
    cfg_rdata                 = '0;
    cfg_rdata[MODE_W-1:0]     = mode_q;
    cfg_rdata[BIT_REMAP]      = remap_q;
    cfg_rdata[BIT_RAMA]       = rama_q;
    cfg_rdata[BIT_DSEL]       = dsel_q;
  end

  always_comb begin
    case (mode_q)
      MODE_W'(0): boot_addr = RESET_VECTOR;
      MODE_W'(2): boot_addr = PROM_BASE;
      default:    boot_addr = BOOT_ROM_BASE;
    endcase
  end

endmodule

// File: rtl/opmode_stop_timer.sv
module opmode_stop_timer
  import opmode_pkg::*;
#(
  parameter int CNT_W     = 16,
  parameter int LONG_DLY  = 65535,
  parameter int SHORT_DLY = 8
) (
  input  logic clk,
  input  logic rst_sync_n,
  input  logic stop_req,
  input  logic wake_evt,
  input  logic dsel,
  output logic resume
);

  localparam logic [CNT_W-1:0] LONG_LD  = CNT_W'(LONG_DLY);
  localparam logic [CNT_W-1:0] SHORT_LD = CNT_W'(SHORT_DLY);

  wake_st_e          st_q, st_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic              pend_q, pend_d;
  logic              cnt_done;

  assign cnt_done = (cnt_q == '0);
  assign resume   = (st_q == ST_DELAY) && cnt_done;

  always_comb begin
    st_d   = st_q;
    cnt_d  = cnt_q;
    pend_d = pend_q;
    case (st_q)
      ST_RUN: begin
        if (stop_req || pend_q) begin
          st_d   = ST_STOP;
          pend_d = 1'b0;
        end
      end
      ST_STOP: begin
        if (wake_evt) begin
          st_d  = ST_DELAY;
          cnt_d = dsel ? SHORT_LD : LONG_LD;
        end
      end
      ST_DELAY: begin
        if (stop_req) begin
          pend_d = 1'b1;
        end
        if (cnt_done) begin
          st_d = ST_RUN;
        end else begin
          cnt_d = cnt_q - 1'b1;
        end
      end
      default: st_d = ST_RUN;
    endcase
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      st_q   <= ST_RUN;
      cnt_q  <= '0;
      pend_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      cnt_q  <= cnt_d;
      pend_q <= pend_d;
    end
  end

endmodule

// File: rtl/opmode_ctrl.sv
module opmode_ctrl
  import opmode_pkg::*;
#(
  parameter int ADDR_W     = 16,
  parameter int CNT_W      = 16,
  parameter int LONG_DLY   = 65535,
  parameter int SHORT_DLY  = 8,
  parameter int RST_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [2:0]        mode_pins,
  input  logic              cfg_we,
  input  logic [7:0]        cfg_wdata,
  output logic [7:0]        cfg_rdata,
  input  logic              stop_req,
  input  logic              wake_evt,
  output logic              resume,
  output logic [ADDR_W-1:0] boot_addr,
  output logic              prog_remap
);

  logic rst_sync_n;
  cfg_t cfg;

  opmode_rst_sync #(.STAGES(RST_STAGES)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  opmode_cfg_reg #(.ADDR_W(ADDR_W)) u_cfg (
    .clk        (clk),
    .rst_sync_n (rst_sync_n),
    .mode_pins  (mode_pins),
    .cfg_we     (cfg_we),
    .cfg_wdata  (cfg_wdata),
    .cfg        (cfg),
    .cfg_rdata  (cfg_rdata),
    .boot_addr  (boot_addr)
  );

  opmode_stop_timer #(
    .CNT_W     (CNT_W),
    .LONG_DLY  (LONG_DLY),
    .SHORT_DLY (SHORT_DLY)
  ) u_timer (
    .clk        (clk),
    .rst_sync_n (rst_sync_n),
    .stop_req   (stop_req),
    .wake_evt   (wake_evt),
    .dsel       (cfg.dsel),
    .resume     (resume)
  );

  assign prog_remap = cfg.remap;

endmodule

// File: rtl/opmode_ctrl_chk.sv
module opmode_ctrl_chk #(
  parameter int ADDR_W = 16
) (
  input logic              clk,
  input logic              rst_sync_n,
  input logic              cfg_we,
  input logic [7:0]        cfg_wdata,
  input logic [7:0]        cfg_rdata,
  input logic              resume,
  input logic [ADDR_W-1:0] boot_addr,
  input logic              prog_remap
);

  a_r1_pins_ignored: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !cfg_we |=> $stable(cfg_rdata[2:0]));

  a_r3_unused_zero: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (cfg_rdata[7] == 1'b0) && (cfg_rdata[5] == 1'b0));

  a_r5_prom_entry: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (cfg_rdata[2:0] == 3'd2) |-> (boot_addr == ADDR_W'(16'h2000)));

  a_r6_remap_written: assert property (@(posedge clk) disable iff (!rst_sync_n)
    cfg_we |=> (prog_remap == $past(cfg_wdata[3])));

  a_r10_single_strobe: assert property (@(posedge clk) disable iff (!rst_sync_n)
    resume |=> !resume);

endmodule

bind opmode_ctrl opmode_ctrl_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk        (clk),
  .rst_sync_n (rst_sync_n),
  .cfg_we     (cfg_we),
  .cfg_wdata  (cfg_wdata),
  .cfg_rdata  (cfg_rdata),
  .resume     (resume),
  .boot_addr  (boot_addr),
  .prog_remap (prog_remap)
);

// File: tb/opmode_ctrl_tb.sv
module opmode_ctrl_tb_top;

  localparam int CLK_P = 10;

  logic        clk;
  logic        rst_n;
  logic [2:0]  mode_pins;
  logic        cfg_we;
  logic [7:0]  cfg_wdata;
  logic [7:0]  cfg_rdata;
  logic        stop_req;
  logic        wake_evt;
  logic        resume;
  logic [15:0] boot_addr;
  logic        prog_remap;

  int n_tests = 0;
  int n_fail  = 0;
  logic [7:0] cur_cfg;

  opmode_ctrl dut_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .mode_pins  (mode_pins),
    .cfg_we     (cfg_we),
    .cfg_wdata  (cfg_wdata),
    .cfg_rdata  (cfg_rdata),
    .stop_req   (stop_req),
    .wake_evt   (wake_evt),
    .resume     (resume),
    .boot_addr  (boot_addr),
    .prog_remap (prog_remap)
  );

  initial clk = 1'b0;
  always #(CLK_P/2) clk = ~clk;

  function automatic logic [15:0] exp_boot(input logic [2:0] m);
    if (m == 3'd0) return 16'h0000;
    if (m == 3'd2) return 16'h2000;
    return 16'h0800;
  endfunction

  function automatic logic [7:0] exp_rd(input logic [7:0] w);
    return w & 8'h5F;
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic check_cfg(input string req);
    chk(cfg_rdata == exp_rd(cur_cfg), {req, " rdata"}, cfg_rdata, exp_rd(cur_cfg));
    chk(prog_remap == cur_cfg[3], "R6 remap", prog_remap, cur_cfg[3]);
    chk(boot_addr == exp_boot(cur_cfg[2:0]), "R5 boot", boot_addr, exp_boot(cur_cfg[2:0]));
  endtask

  task automatic do_reset(input logic [2:0] pins);
    @(negedge clk);
    rst_n = 1'b0;
    mode_pins = pins;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    mode_pins = ~pins;
    repeat (2) @(negedge clk);
    cur_cfg = {5'd0, (pins == 3'd0) ? 3'd1 : pins};
  endtask

  task automatic cfg_write(input logic [7:0] w);
    cfg_we = 1'b1;
    cfg_wdata = w;
    @(negedge clk);
    cfg_we = 1'b0;
    cur_cfg = exp_rd(w);
  endtask

  task automatic do_stop();
    stop_req = 1'b1;
    @(negedge clk);
    stop_req = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  // Wake a stopped block and count edges until resume; optional actions three edges in.
  task automatic wake_and_time(input int exp_n, input string req, input bit poke_dsel,
                               input bit poke_stop, input bit poke_wake);
    int edges = 0;
    bit seen = 1'b0;
    wake_evt = 1'b1;
    @(posedge clk);
    @(negedge clk);
    wake_evt = 1'b0;
    while (edges < 70000) begin
      @(posedge clk);
      edges++;
      @(negedge clk);
      cfg_we = 1'b0;
      stop_req = 1'b0;
      wake_evt = 1'b0;
      if (resume) begin
        seen = 1'b1;
        break;
      end
      if (edges == 3) begin
        if (poke_dsel) begin
          cfg_we = 1'b1;
          cfg_wdata = cur_cfg ^ 8'h40;
          cur_cfg = exp_rd(cur_cfg ^ 8'h40);
        end
        if (poke_stop) stop_req = 1'b1;
        if (poke_wake) wake_evt = 1'b1;
      end
    end
    chk(seen && edges == exp_n, req, edges, exp_n);
    @(negedge clk);
    chk(!resume, "R10 strobe width", resume, 0);
  endtask

  task automatic expect_no_resume(input int cycles, input string req);
    bit hit = 1'b0;
    for (int i = 0; i < cycles; i++) begin
      @(negedge clk);
      if (resume) hit = 1'b1;
    end
    chk(!hit, req, hit, 0);
  endtask

  initial begin
    #(CLK_P * 190000);
    n_fail++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    int seed;
    logic [7:0] w;
    seed = $urandom(32'h5EED1);
    rst_n = 1'b0;
    mode_pins = 3'd0;
    cfg_we = 1'b0;
    cfg_wdata = '0;
    stop_req = 1'b0;
    wake_evt = 1'b0;
    cur_cfg = '0;

    // R1, R2, R4: capture of every strap value
    for (int p = 0; p < 8; p++) begin
      do_reset(3'(p));
      chk(cfg_rdata[2:0] == ((p == 0) ? 3'd1 : 3'(p)), (p == 0) ? "R2 mode0 promoted" : "R1 strap capture",
          cfg_rdata[2:0], (p == 0) ? 1 : p);
      chk(cfg_rdata[6:3] == 4'd0, "R4 flags cleared", cfg_rdata, 0);
      check_cfg("R1");
    end

    // R4: reset after flags were set
    cfg_write(8'hFF);
    check_cfg("R3");
    do_reset(3'd2);
    chk(cfg_rdata == 8'h02, "R4 reset clears flags", cfg_rdata, 8'h02);

    // R3, R5, R6: directed then random writes
    cfg_write(8'h08);
    check_cfg("R3 mode0 write");
    cfg_write(8'h02);
    check_cfg("R3 mode2 write");
    for (int i = 0; i < 40; i++) begin
      w = 8'($urandom);
      cfg_write(w);
      check_cfg("R3 random write");
    end
    mode_pins = 3'd0;
    repeat (3) @(negedge clk);
    check_cfg("R1 pins ignored after reset");

    // R11: wake while running
    cfg_write(8'h41);
    wake_evt = 1'b1;
    @(negedge clk);
    wake_evt = 1'b0;
    expect_no_resume(30, "R11 wake while running");

    // R7: short delay
    do_stop();
    wake_and_time(8, "R7 short delay", 1'b0, 1'b0, 1'b0);
    // R11: extra wakeup during count does not restart it
    do_stop();
    wake_and_time(8, "R11 wake during delay", 1'b0, 1'b0, 1'b1);
    expect_no_resume(20, "R11 no second strobe");
    // R9: clearing delay-select mid-count keeps the short delay
    do_stop();
    wake_and_time(8, "R9 short kept", 1'b1, 1'b0, 1'b0);
    // R12: stop request held through the count
    cfg_write(8'h41);
    do_stop();
    wake_and_time(8, "R12 stop during delay", 1'b0, 1'b1, 1'b0);
    repeat (3) @(negedge clk);
    wake_and_time(8, "R12 stopped after resume", 1'b0, 1'b0, 1'b0);

    // R8, R9: long delay with delay-select set mid-count
    cfg_write(8'h01);
    do_stop();
    wake_and_time(65535, "R8 long delay", 1'b1, 1'b0, 1'b0);

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule